// File: doc/BRIEF.md
# Machine-Cycle Timing and State Sequencer

This block paces a small byte-wide processor. It divides the input clock into machine cycles of eight clock periods. In each cycle it places the two timing strobes, the switch from the high to the low address byte, and a write-strobe window. At the end of every cycle it picks the next cycle type: instruction fetch, execute, direct-memory-access transfer or interrupt entry. It shows that type on a two-bit state code. The datapath and the instruction decoder sit outside. They drive the sequencer with an extra-execute request, an idle request, and already-qualified DMA and interrupt requests.

Two control inputs, `clear_n` and `wait_n`, select reset, pause or run. Reset is sampled on the clock edge. After reset is released, the block runs one lengthened initialization cycle of nine clocks. During it, pending requests do not change its length. A hardware pause can only freeze the cycle while one of the two strobes is high. A software idle parks the cycle on the second strobe and floats the bus. The idle ends only on a DMA or interrupt request, or on reset.

Top module: `mc_sequencer`

## Requirements
- R1: While `clear_n` is low, whatever the level of `wait_n` (low/low is treated as reset), every clock edge forces the state code to 01 (execute). The same edge drives `tpa`, `tpb`, `addr_lo_sel`, `wr_strobe`, `bus_float` and `flag_sample` low.
- R2: The first cycle after `clear_n` rises lasts 9 clocks with the state code held at 01. `tpa` is high on the second of those clocks. Requests do not lengthen or end this cycle. The next cycle is DMA (10) if `dma_req` is high at its last clock, and otherwise fetch (00). It is never execute or interrupt entry.
- R3: Every later cycle lasts 8 clocks unless stopped. Number the clocks of a cycle p = 0..7. Then `tpa` is high only at p = 1 and `tpb` only at p = 6. `addr_lo_sel` is high for p >= 2, and `wr_strobe` is high at p = 5 and p = 6.
- R4: The state code encoding is fetch = 00, execute = 01, DMA = 10, interrupt entry = 11. A fetch cycle is always followed by an execute cycle.
- R5: At the end of an execute cycle without an extra-execute request, the next cycle is chosen in priority order: DMA if `dma_req` is high, otherwise interrupt if `irq_req` is high, otherwise fetch.
- R6: At the end of a DMA cycle the next cycle is DMA if `dma_req` is high, otherwise interrupt if `irq_req` is high, otherwise fetch. At the end of an interrupt cycle it is DMA if `dma_req` is high, otherwise fetch.
- R7: `extra_exec` high at the last clock of an execute cycle gives another execute cycle. Pending DMA and interrupt requests wait until an execute cycle ends without it.
- R8: `flag_sample` is high for exactly the last clock (p = 7) of a fetch cycle and low at all other times.
- R9: With `clear_n` high and `wait_n` low, the cycle keeps advancing until `tpa` or `tpb` is high. It then freezes there with that strobe held high and the state code unchanged. One clock after `wait_n` returns high, the cycle moves to the next phase.
- R10: If `idle_req` is high on the clock that moves an execute cycle (not the initialization cycle) into p = 6, the cycle stops there. While stopped, `tpb` stays high, `bus_float` is high and `wr_strobe` is low. The stop holds until `dma_req` or `irq_req` is seen. One clock later `bus_float` falls. One clock after that the cycle reaches p = 7, and it then ends by the R5 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one machine cycle is eight of its periods |
| clear_n | input | 1 | Active-low reset control, sampled on the clock edge |
| wait_n | input | 1 | Active-low pause control (effective while clear_n is high) |
| dma_req | input | 1 | Qualified DMA request |
| irq_req | input | 1 | Qualified interrupt request |
| extra_exec | input | 1 | Requests another execute cycle after the current one |
| idle_req | input | 1 | Requests an idle stop in the current execute cycle |
| tpa | output | 1 | First timing strobe |
| tpb | output | 1 | Second timing strobe |
| addr_lo_sel | output | 1 | 0: present the high address byte, 1: the low byte |
| wr_strobe | output | 1 | Write-pulse window |
| bus_float | output | 1 | High while idle-stopped: data bus released |
| flag_sample | output | 1 | One-clock pulse at the end of a fetch cycle |
| state_code | output | 2 | Current cycle type (00 fetch, 01 execute, 10 DMA, 11 interrupt) |

## Verification
Several machine cycles are swept phase by phase, so each strobe's position and width is compared with the phase number. The swept cycles include fetch and execute cycles, which separates the fetch-only flag pulse from the others. The cycle-type chain is driven with DMA alone, interrupt alone, both together, and both held behind an extra-execute request, which separates priority from deferral. A pause requested away from a strobe, a pause landing on each strobe, and an idle stop ended by an interrupt each exercise a different freeze path. Reset mid-cycle, with the illegal control pair, and then initialization with an interrupt or a DMA request pending show both the nine-clock length and which successor the initialization cycle may take.

// File: rtl/mcs_pkg.sv
// Package: shared cycle-type encoding for the machine-cycle sequencer.
// Assumes: the two-bit code is driven straight onto the state code pins.
package mcs_pkg;
    typedef enum logic [1:0] {
        ST_FETCH = 2'b00,
        ST_EXEC  = 2'b01,
        ST_DMA   = 2'b10,
        ST_INTR  = 2'b11
    } mc_state_t;
endpackage

// File: rtl/mcs_phase_ctr.sv
// Module: clock-phase counter for one machine cycle.
// Counts 0..CYCLE_LEN-1 and adds one extra leading clock after reset
// (lengthened first cycle). Freezes while hold is high.
// Assumes: clear_n is a synchronous active-low reset.
module mcs_phase_ctr #(
    parameter int CYCLE_LEN = 8,
    parameter int PH_W      = $clog2(CYCLE_LEN)
) (
    input  logic            clk,
    input  logic            clear_n,
    input  logic            hold,
    output logic [PH_W-1:0] phase,
    output logic            cyc_end
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYCLE_LEN - 1);

    logic pre_q;

    // Phase advance, with a single leading extra clock after reset
    always_ff @(posedge clk) begin
        if (!clear_n) begin
            phase <= '0;
            pre_q <= 1'b1;
        end else if (pre_q) begin
            pre_q <= 1'b0;
        end else if (!hold) begin
            phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
        end
    end

    // Last clock of a cycle that will actually advance
    always_comb cyc_end = !pre_q && !hold && (phase == LAST_PH);
endmodule

// File: rtl/mcs_next_state.sv
// Module: chooses the next cycle type at the end of a machine cycle.
// Priority: DMA over interrupt; extra execute defers both; the
// initialization cycle may only be followed by fetch or DMA.
// Assumes: requests are already qualified by their enables.
module mcs_next_state
    import mcs_pkg::*;
(
    input  mc_state_t cur,
    input  logic      init,
    input  logic      extra_exec,
    input  logic      dma_req,
    input  logic      irq_req,
    output mc_state_t nxt
);
    // Successor table
    always_comb begin
        nxt = ST_FETCH;
        if (init) begin
            nxt = dma_req ? ST_DMA : ST_FETCH;
        end else begin
            unique case (cur)
                ST_FETCH: nxt = ST_EXEC;
                ST_EXEC:  nxt = extra_exec ? ST_EXEC :
                                dma_req    ? ST_DMA  :
                                irq_req    ? ST_INTR : ST_FETCH;
                ST_DMA:   nxt = dma_req ? ST_DMA  :
                                irq_req ? ST_INTR : ST_FETCH;
                ST_INTR:  nxt = dma_req ? ST_DMA : ST_FETCH;
                default:  nxt = ST_FETCH;
            endcase
        end
    end
endmodule

// File: rtl/mcs_strobes.sv
// Module: decodes the phase number into the cycle's timing strobes.
// Assumes: phase is registered, so every output is glitch-free per clock.
module mcs_strobes #(
    parameter int PH_W     = 3,
    parameter int TPA_PH   = 1,
    parameter int TPB_PH   = 6,
    parameter int LO_PH    = 2,
    parameter int WR_FIRST = 5,
    parameter int WR_LAST  = 6
) (
    input  logic [PH_W-1:0] phase,
    input  logic            idle_stop,
    output logic            tpa,
    output logic            tpb,
    output logic            addr_lo_sel,
    output logic            wr_strobe,
    output logic            bus_float
);
    localparam logic [PH_W-1:0] P_TPA = PH_W'(TPA_PH);
    localparam logic [PH_W-1:0] P_TPB = PH_W'(TPB_PH);
    localparam logic [PH_W-1:0] P_LO  = PH_W'(LO_PH);
    localparam logic [PH_W-1:0] P_WR0 = PH_W'(WR_FIRST);
    localparam logic [PH_W-1:0] P_WR1 = PH_W'(WR_LAST);

    // Strobe decode; the idle stop suppresses the write window
    always_comb begin
        tpa         = (phase == P_TPA);
        tpb         = (phase == P_TPB);
        addr_lo_sel = (phase >= P_LO);
        wr_strobe   = (phase >= P_WR0) && (phase <= P_WR1) && !idle_stop;
        bus_float   = idle_stop;
    end
endmodule

// File: rtl/mc_sequencer.sv
// Module: machine-cycle timing and state sequencer (top).
// Holds the cycle type, the initialization flag and the idle stop, and
// combines the pause/idle freeze into the phase counter's hold.
// Assumes: clear_n low is reset (also with wait_n low); all inputs are
// synchronous to clk.
module mc_sequencer
    import mcs_pkg::*;
#(
    parameter int CYCLE_LEN = 8,
    parameter int TPA_PH    = 1,
    parameter int TPB_PH    = 6,
    parameter int LO_PH     = 2,
    parameter int WR_FIRST  = 5,
    parameter int WR_LAST   = 6
) (
    input  logic       clk,
    input  logic       clear_n,
    input  logic       wait_n,
    input  logic       dma_req,
    input  logic       irq_req,
    input  logic       extra_exec,
    input  logic       idle_req,
    output logic       tpa,
    output logic       tpb,
    output logic       addr_lo_sel,
    output logic       wr_strobe,
    output logic       bus_float,
    output logic       flag_sample,
    output logic [1:0] state_code
);
    localparam int              PH_W    = $clog2(CYCLE_LEN);
    localparam logic [PH_W-1:0] P_TPA   = PH_W'(TPA_PH);
    localparam logic [PH_W-1:0] P_TPB   = PH_W'(TPB_PH);
    localparam logic [PH_W-1:0] P_PRETB = PH_W'(TPB_PH - 1);

    mc_state_t       state_q, state_nx;
    logic            init_q, idle_q, hold, cyc_end;
    logic [PH_W-1:0] phase;

    // Freeze: idle stop, or pause while a strobe is high
    always_comb hold = idle_q ||
                       (clear_n && !wait_n && (phase == P_TPA || phase == P_TPB));

    mcs_phase_ctr #(.CYCLE_LEN(CYCLE_LEN), .PH_W(PH_W)) u_phase (
        .clk     (clk),
        .clear_n (clear_n),
        .hold    (hold),
        .phase   (phase),
        .cyc_end (cyc_end)
    );

    mcs_next_state u_next (
        .cur        (state_q),
        .init       (init_q),
        .extra_exec (extra_exec),
        .dma_req    (dma_req),
        .irq_req    (irq_req),
        .nxt        (state_nx)
    );

    mcs_strobes #(
        .PH_W(PH_W), .TPA_PH(TPA_PH), .TPB_PH(TPB_PH), .LO_PH(LO_PH),
        .WR_FIRST(WR_FIRST), .WR_LAST(WR_LAST)
    ) u_strobes (
        .phase       (phase),
        .idle_stop   (idle_q),
        .tpa         (tpa),
        .tpb         (tpb),
        .addr_lo_sel (addr_lo_sel),
        .wr_strobe   (wr_strobe),
        .bus_float   (bus_float)
    );

    // Cycle type and initialization flag, updated at each cycle end
    always_ff @(posedge clk) begin
        if (!clear_n) begin
            state_q <= ST_EXEC;
            init_q  <= 1'b1;
        end else if (cyc_end) begin
            state_q <= state_nx;
            init_q  <= 1'b0;
        end
    end

    // Idle stop: armed on entry to the second strobe, released by a request
    always_ff @(posedge clk) begin
        if (!clear_n) begin
            idle_q <= 1'b0;
        end else if (idle_q) begin
            if (dma_req || irq_req) idle_q <= 1'b0;
        end else if (state_q == ST_EXEC && !init_q && phase == P_PRETB &&
                     !hold && idle_req) begin
            idle_q <= 1'b1;
        end
    end

    // Outputs taken from the state register
    always_comb begin
        state_code  = state_q;
        flag_sample = cyc_end && (state_q == ST_FETCH);
    end

    // R3
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!clear_n)
        !(tpa && tpb));

    // R2
    init_successor_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (init_q && cyc_end) |=> (state_code == 2'b00 || state_code == 2'b10));

    // R7
    extra_exec_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (state_code == 2'b01 && cyc_end && extra_exec) |=> (state_code == 2'b01));

    // R9
    pause_holds_tpa_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (!wait_n && tpa) |=> (tpa && $stable(state_code)));

    // R10
    idle_stays_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (bus_float && !dma_req && !irq_req) |=> (bus_float && tpb && !wr_strobe));
endmodule

// File: tb/tb_mc_sequencer.sv
`timescale 1ns/1ps
module tb_mc_sequencer;
    logic clk = 1'b0;
    logic clear_n, wait_n, dma_req, irq_req, extra_exec, idle_req;
    logic tpa, tpb, addr_lo_sel, wr_strobe, bus_float, flag_sample;
    logic [1:0] state_code;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mc_sequencer dut (
        .clk(clk), .clear_n(clear_n), .wait_n(wait_n), .dma_req(dma_req),
        .irq_req(irq_req), .extra_exec(extra_exec), .idle_req(idle_req),
        .tpa(tpa), .tpb(tpb), .addr_lo_sel(addr_lo_sel), .wr_strobe(wr_strobe),
        .bus_float(bus_float), .flag_sample(flag_sample), .state_code(state_code)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sweep one cycle from p=0; expected strobes from phase arithmetic (R3, R8)
    task automatic sweep(input int st);
        for (int p = 0; p < 8; p++) begin
            if (p > 0) tick();
            chk("R3 tpa", int'(tpa), int'(p == 1));
            chk("R3 tpb", int'(tpb), int'(p == 6));
            chk("R3 addr_lo_sel", int'(addr_lo_sel), int'(p >= 2));
            chk("R3 wr_strobe", int'(wr_strobe), int'(p == 5 || p == 6));
            chk("R8 flag_sample", int'(flag_sample), int'(st == 0 && p == 7));
            chk("R4 state_code", int'(state_code), st);
        end
    endtask

    // Count clocks of the initialization cycle after release (R2)
    task automatic run_init(input int exp_next);
        int n = 0;
        clear_n = 1'b1;
        do begin
            tick();
            n++;
            if (n == 2) chk("R2 tpa on 2nd clock", int'(tpa), 1);
        end while (state_code == 2'b01 && n < 30);
        chk("R2 init length", n, 9);
        chk("R2 init successor", int'(state_code), exp_next);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        clear_n = 1'b0; wait_n = 1'b1; dma_req = 1'b0; irq_req = 1'b0;
        extra_exec = 1'b0; idle_req = 1'b0;
        tick(3);
        // R1 reset state
        chk("R1 state_code", int'(state_code), 1);
        chk("R1 tpa", int'(tpa), 0);
        chk("R1 tpb", int'(tpb), 0);
        chk("R1 addr_lo_sel", int'(addr_lo_sel), 0);
        chk("R1 wr_strobe", int'(wr_strobe), 0);
        chk("R1 bus_float", int'(bus_float), 0);
        chk("R1 flag_sample", int'(flag_sample), 0);
        run_init(0);

        // R3 R8 phase sweeps over fetch, execute, fetch
        sweep(0); tick();
        sweep(1); tick();
        sweep(0); tick();

        // R7 extra execute defers a DMA request
        extra_exec = 1'b1; dma_req = 1'b1;
        tick(8); chk("R7 extra exec repeats", int'(state_code), 1);
        extra_exec = 1'b0;
        tick(8); chk("R5 exec then DMA", int'(state_code), 2);
        tick(8); chk("R6 DMA held", int'(state_code), 2);
        dma_req = 1'b0; irq_req = 1'b1;
        tick(8); chk("R6 DMA then interrupt", int'(state_code), 3);
        irq_req = 1'b0;
        tick(8); chk("R6 interrupt then fetch", int'(state_code), 0);
        tick(8); chk("R4 fetch then exec", int'(state_code), 1);
        dma_req = 1'b1; irq_req = 1'b1;
        tick(8); chk("R5 DMA priority", int'(state_code), 2);
        dma_req = 1'b0;
        tick(8); chk("R6 DMA then interrupt", int'(state_code), 3);
        irq_req = 1'b0;
        tick(8); chk("R6 interrupt then fetch", int'(state_code), 0);
        tick(8); chk("R4 fetch then exec", int'(state_code), 1);
        irq_req = 1'b1;
        tick(8); chk("R5 exec then interrupt", int'(state_code), 3);
        dma_req = 1'b1; irq_req = 1'b0;
        tick(8); chk("R6 interrupt then DMA", int'(state_code), 2);
        dma_req = 1'b0;
        tick(8); chk("R6 DMA then fetch", int'(state_code), 0);

        // R9 pause requested at p=3 runs on to tpb, then freezes
        tick(3); wait_n = 1'b0;
        tick(2); chk("R9 runs past non-strobe", int'(wr_strobe), 1);
        tick(); chk("R9 reaches tpb", int'(tpb), 1);
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R9 tpb held", int'(tpb), 1);
            chk("R9 state held", int'(state_code), 0);
        end
        wait_n = 1'b1;
        tick(); chk("R9 resume tpb low", int'(tpb), 0);
        chk("R9 resume flag at p7", int'(flag_sample), 1);
        tick(); chk("R9 next cycle", int'(state_code), 1);
        // R9 pause landing on tpa
        wait_n = 1'b0;
        tick(); chk("R9 reaches tpa", int'(tpa), 1);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R9 tpa held", int'(tpa), 1);
        end
        wait_n = 1'b1;
        tick(); chk("R9 resume tpa low", int'(tpa), 0);
        chk("R9 low byte after tpa", int'(addr_lo_sel), 1);
        tick(6); chk("R9 next cycle fetch", int'(state_code), 0);

        // R10 idle stop in execute, released by interrupt
        tick(8); idle_req = 1'b1;
        tick(6); idle_req = 1'b0;
        chk("R10 stop on tpb", int'(tpb), 1);
        chk("R10 bus floats", int'(bus_float), 1);
        chk("R10 write off", int'(wr_strobe), 0);
        tick(20);
        chk("R10 still stopped tpb", int'(tpb), 1);
        chk("R10 still floating", int'(bus_float), 1);
        chk("R10 still execute", int'(state_code), 1);
        irq_req = 1'b1;
        tick(); chk("R10 float released", int'(bus_float), 0);
        chk("R10 phase held one clock", int'(tpb), 1);
        tick(); chk("R10 phase resumes", int'(tpb), 0);
        tick(); chk("R10 exit to interrupt", int'(state_code), 3);
        irq_req = 1'b0;
        tick(8); chk("R6 interrupt then fetch", int'(state_code), 0);

        // R1 reset mid-cycle, also with the illegal pair
        tick(4); clear_n = 1'b0;
        tick(); chk("R1 mid-cycle state", int'(state_code), 1);
        chk("R1 mid-cycle addr", int'(addr_lo_sel), 0);
        wait_n = 1'b0;
        tick(2); chk("R1 low/low is reset", int'(state_code), 1);
        chk("R1 low/low tpb", int'(tpb), 0);
        wait_n = 1'b1; irq_req = 1'b1;
        // R2 interrupt ignored during init, successor fetch
        run_init(0);
        irq_req = 1'b0;
        tick(); clear_n = 1'b0; tick(2);
        dma_req = 1'b1;
        // R2 DMA successor of init
        run_init(2);
        dma_req = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule